// File: doc/BRIEF.md
# Ping-Pong Membrane Potential Store

This block holds the membrane potential of every neuron in one layer of a spiking network accelerator. The neuron update logic sits outside it. Each inference, that logic streams the old potentials out in neuron order and streams the updated potentials back in, also in neuron order. A true dual-port memory is not available, so the store uses two single-port banks. In any inference one bank is only read and the other is only written. A bank-select bit swaps the two roles each time a new inference starts. The bank that was filled last time therefore becomes the source for the next pass.

Between inferences a host port can load initial potentials and read back final ones. This port always addresses the bank that was written most recently, which is also the bank the next inference will read. A clear command writes zero into every word of both banks. It holds `busy` high for exactly one cycle per word. The neuron count in use is taken from `neuronCount`, which is limited internally to the bank depth.

Top module: `potential_pingpong_store`

## Requirements
- R1: After reset the store is idle: `busy`, `running`, `rdValid` and `hostRdValid` are all low, and the bank select is 0, so the host port addresses bank 1.
- R2: A `clearReq` taken while not busy raises `busy` on the next cycle and holds it for exactly DEPTH cycles. During that time zero is written to every address of both banks, and any inference in progress is abandoned.
- R3: When idle, `hostWrReq` writes `hostWrData` at `hostAddr` into the most recently written bank. `hostRdReq` without `hostWrReq` reads that bank and returns the word on `dataOut` with `hostRdValid` high in the cycle after the request is sampled.
- R4: An `inferStart` taken while idle toggles the bank select, resets both stream pointers to entry 0 and raises `running`. Each accepted `rdReq` then returns the next entry of the read bank (the previously written bank) on `dataOut`, with `rdValid` high one cycle after the request.
- R5: Each accepted `wrReq` stores `wrData` at the next entry of the other bank, in neuron order. After the inference ends, host readback returns exactly those words.
- R6: An `inferStart` that arrives while an inference is running and its write pointer is below the neuron count is ignored. The roles do not swap and the stream continues.
- R7: Reads and writes beyond the neuron count are ignored: `rdValid` stays low, and entries at or above the count in the written bank keep their earlier contents. `running` falls one cycle after the write pointer reaches the count.
- R8: Host reads and writes are ignored while an inference is running or a clear is in progress. No `hostRdValid` is produced and no entry changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| neuronCount | input | AW+1 | Neurons in the layer, capped at DEPTH |
| inferStart | input | 1 | Start-of-inference pulse; swaps bank roles when accepted |
| clearReq | input | 1 | Zero both banks |
| busy | output | 1 | Clear in progress |
| running | output | 1 | Inference streaming in progress |
| rdReq | input | 1 | Pop the next old potential |
| wrReq | input | 1 | Push the next updated potential |
| wrData | input | DATA_W | Updated potential |
| rdValid | output | 1 | `dataOut` holds a streamed potential |
| hostRdReq | input | 1 | Host read of the last written bank |
| hostWrReq | input | 1 | Host write of the last written bank |
| hostAddr | input | AW | Host word address |
| hostWrData | input | DATA_W | Host write data |
| hostRdValid | output | 1 | `dataOut` holds a host readback word |
| dataOut | output | DATA_W | Shared read data |

## Verification
A bank select stuck or flipped at the wrong moment shows at once. The first streamed word of the next inference, or the first host readback word, comes from the wrong bank. A rejected mid-run start that swapped anyway would send the remaining writes into the read bank, and the host readback after that pass would not match. A pointer that fails to reset or that runs past the count shows up as a shifted word or a stray valid within one word of the boundary. A clear that is too short leaves a nonzero word, or changes the `busy` length, visible on the cycle it ends.

// File: rtl/mpp_pkg.sv
package mpp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_CLEAR = 2'd2
  } ctlState_t;

  typedef enum logic [1:0] {
    SRC_STREAM = 2'd0,
    SRC_HOST   = 2'd1,
    SRC_ZERO   = 2'd2
  } dataSrc_t;

  // Per-cycle strobes from control to datapath.
  typedef struct packed {
    logic [1:0] bankEn;
    logic [1:0] bankWe;
    dataSrc_t   dataSrc;
    logic       outBank;
    logic       streamRd;
    logic       hostRd;
  } strobe_t;

endpackage

// File: rtl/mpp_bank.sv
module mpp_bank #(
  parameter int DATA_W = 32,
  parameter int AW     = 10
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  localparam int WORDS = 1 << AW;

  logic [DATA_W-1:0] mem [WORDS];

  // One port: a cycle is either a write or a synchronous read.
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    q         <= mem[addr];
    end
  end
endmodule

// File: rtl/mpp_ctrl.sv
module mpp_ctrl
  import mpp_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int AW    = 10
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW:0]   neuronCount,
  input  logic          inferStart,
  input  logic          clearReq,
  input  logic          rdReq,
  input  logic          wrReq,
  input  logic          hostRdReq,
  input  logic          hostWrReq,
  input  logic [AW-1:0] hostAddr,
  output strobe_t       strobe,
  output logic [AW-1:0] addr0,
  output logic [AW-1:0] addr1,
  output logic          busy,
  output logic          running
);
  localparam int CW = AW + 1;

  ctlState_t     state;
  logic          bankSel;
  logic [CW-1:0] rdPtr, wrPtr, cntEff;
  logic [AW-1:0] clrCnt;
  logic [AW-1:0] bankAddr [2];
  logic          rdBank, wrBank;
  logic          clrGo, startOk, rdAcc, wrAcc, hostOk, hostWrAcc, hostRdAcc;

  always_comb begin
    cntEff    = (neuronCount > CW'(DEPTH)) ? CW'(DEPTH) : neuronCount;
    rdBank    = bankSel;
    wrBank    = ~bankSel;
    clrGo     = clearReq && (state != ST_CLEAR);
    startOk   = inferStart && !clrGo &&
                ((state == ST_IDLE) || ((state == ST_RUN) && (wrPtr == cntEff)));
    rdAcc     = (state == ST_RUN) && rdReq && (rdPtr < cntEff) && !clrGo && !startOk;
    wrAcc     = (state == ST_RUN) && wrReq && (wrPtr < cntEff) && !clrGo && !startOk;
    hostOk    = (state == ST_IDLE) && !clrGo && !startOk;
    hostWrAcc = hostOk && hostWrReq;
    hostRdAcc = hostOk && hostRdReq && !hostWrReq;
  end

  always_comb begin
    strobe      = '0;
    bankAddr[0] = '0;
    bankAddr[1] = '0;
    if (state == ST_CLEAR) begin
      strobe.bankEn  = 2'b11;
      strobe.bankWe  = 2'b11;
      strobe.dataSrc = SRC_ZERO;
      bankAddr[0]    = clrCnt;
      bankAddr[1]    = clrCnt;
    end else begin
      if (rdAcc) begin
        strobe.bankEn[rdBank] = 1'b1;
        bankAddr[rdBank]      = rdPtr[AW-1:0];
        strobe.streamRd       = 1'b1;
        strobe.outBank        = rdBank;
      end
      if (wrAcc) begin
        strobe.bankEn[wrBank] = 1'b1;
        strobe.bankWe[wrBank] = 1'b1;
        bankAddr[wrBank]      = wrPtr[AW-1:0];
        strobe.dataSrc        = SRC_STREAM;
      end
      if (hostWrAcc) begin
        strobe.bankEn[wrBank] = 1'b1;
        strobe.bankWe[wrBank] = 1'b1;
        bankAddr[wrBank]      = hostAddr;
        strobe.dataSrc        = SRC_HOST;
      end
      if (hostRdAcc) begin
        strobe.bankEn[wrBank] = 1'b1;
        bankAddr[wrBank]      = hostAddr;
        strobe.hostRd         = 1'b1;
        strobe.outBank        = wrBank;
      end
    end
  end

  assign addr0   = bankAddr[0];
  assign addr1   = bankAddr[1];
  assign busy    = (state == ST_CLEAR);
  assign running = (state == ST_RUN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bankSel <= 1'b0;
      rdPtr   <= '0;
      wrPtr   <= '0;
      clrCnt  <= '0;
    end else if (clrGo) begin
      state  <= ST_CLEAR;
      clrCnt <= '0;
      rdPtr  <= '0;
      wrPtr  <= '0;
    end else if (state == ST_CLEAR) begin
      clrCnt <= clrCnt + 1'b1;
      if (clrCnt == AW'(DEPTH - 1)) state <= ST_IDLE;
    end else if (startOk) begin
      bankSel <= ~bankSel;
      rdPtr   <= '0;
      wrPtr   <= '0;
      state   <= ST_RUN;
    end else if (state == ST_RUN) begin
      if (rdAcc) rdPtr <= rdPtr + 1'b1;
      if (wrAcc) wrPtr <= wrPtr + 1'b1;
      if (wrPtr == cntEff) state <= ST_IDLE;
    end
  end

  // The bank being read in a pass is never written (R4).
  p_read_bank_clean_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN) |-> !strobe.bankWe[bankSel]);

  // A start during an unfinished pass leaves the roles alone (R6).
  p_no_early_swap_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_RUN) && (wrPtr < cntEff) && !clearReq) |=> $stable(bankSel));

  // No bank write once the pass has written its last neuron (R7).
  p_write_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_RUN) && (wrPtr == cntEff)) |-> (strobe.bankWe == 2'b00));

  // The clear always sweeps up to the last address (R2).
  p_clear_sweep_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> ($past(clrCnt) == AW'(DEPTH - 1)));

  // No host traffic outside idle (R8).
  p_host_idle_only_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |-> (!strobe.hostRd && (strobe.dataSrc != SRC_HOST)));
endmodule

// File: rtl/mpp_datapath.sv
module mpp_datapath
  import mpp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AW     = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [AW-1:0]     addr0,
  input  logic [AW-1:0]     addr1,
  input  logic [DATA_W-1:0] streamWr,
  input  logic [DATA_W-1:0] hostWr,
  output logic [DATA_W-1:0] dataOut,
  output logic              streamValid,
  output logic              hostValid
);
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] bankQ [2];
  logic [AW-1:0]     bankAddr [2];
  logic              outBankQ;

  always_comb begin
    case (strobe.dataSrc)
      SRC_HOST: wdata = hostWr;
      SRC_ZERO: wdata = '0;
      default:  wdata = streamWr;
    endcase
  end

  assign bankAddr[0] = addr0;
  assign bankAddr[1] = addr1;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    mpp_bank #(.DATA_W(DATA_W), .AW(AW)) u_bank (
      .clk  (clk),
      .en   (strobe.bankEn[b]),
      .we   (strobe.bankWe[b]),
      .addr (bankAddr[b]),
      .wdata(wdata),
      .q    (bankQ[b])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outBankQ    <= 1'b0;
      streamValid <= 1'b0;
      hostValid   <= 1'b0;
    end else begin
      streamValid <= strobe.streamRd;
      hostValid   <= strobe.hostRd;
      if (strobe.streamRd || strobe.hostRd) outBankQ <= strobe.outBank;
    end
  end

  assign dataOut = bankQ[outBankQ];

  // Stream and host reads never share a cycle (R3).
  p_valid_exclusive_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(streamValid && hostValid));

  // Both banks are written together only by the zeroing sweep (R2).
  p_dual_write_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.bankWe == 2'b11) |-> (wdata == '0));
endmodule

// File: rtl/potential_pingpong_store.sv
module potential_pingpong_store
  import mpp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 1024,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [AW:0]       neuronCount,
  input  logic              inferStart,
  input  logic              clearReq,
  output logic              busy,
  output logic              running,
  input  logic              rdReq,
  input  logic              wrReq,
  input  logic [DATA_W-1:0] wrData,
  output logic              rdValid,
  input  logic              hostRdReq,
  input  logic              hostWrReq,
  input  logic [AW-1:0]     hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  output logic              hostRdValid,
  output logic [DATA_W-1:0] dataOut
);
  strobe_t       strobe;
  logic [AW-1:0] addr0, addr1;

  mpp_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .neuronCount(neuronCount),
    .inferStart (inferStart),
    .clearReq   (clearReq),
    .rdReq      (rdReq),
    .wrReq      (wrReq),
    .hostRdReq  (hostRdReq),
    .hostWrReq  (hostWrReq),
    .hostAddr   (hostAddr),
    .strobe     (strobe),
    .addr0      (addr0),
    .addr1      (addr1),
    .busy       (busy),
    .running    (running)
  );

  mpp_datapath #(.DATA_W(DATA_W), .AW(AW)) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .addr0      (addr0),
    .addr1      (addr1),
    .streamWr   (wrData),
    .hostWr     (hostWrData),
    .dataOut    (dataOut),
    .streamValid(rdValid),
    .hostValid  (hostRdValid)
  );
endmodule

// File: tb/potential_pingpong_store_bench.sv
module potential_pingpong_store_bench;
  localparam int DW    = 32;
  localparam int DEPTH = 16;
  localparam int AW    = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW:0]   neuronCount = '0;
  logic          inferStart = 1'b0, clearReq = 1'b0, rdReq = 1'b0, wrReq = 1'b0;
  logic [DW-1:0] wrData = '0, hostWrData = '0;
  logic          hostRdReq = 1'b0, hostWrReq = 1'b0;
  logic [AW-1:0] hostAddr = '0;
  logic          busy, running, rdValid, hostRdValid;
  logic [DW-1:0] dataOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  potential_pingpong_store #(.DATA_W(DW), .DEPTH(DEPTH)) u_potential_pingpong_store (
    .clk(clk), .rstN(rstN), .neuronCount(neuronCount), .inferStart(inferStart),
    .clearReq(clearReq), .busy(busy), .running(running), .rdReq(rdReq),
    .wrReq(wrReq), .wrData(wrData), .rdValid(rdValid), .hostRdReq(hostRdReq),
    .hostWrReq(hostWrReq), .hostAddr(hostAddr), .hostWrData(hostWrData),
    .hostRdValid(hostRdValid), .dataOut(dataOut)
  );

  function automatic logic [DW-1:0] v1(int i); return 32'h1000_0000 + DW'(i * i * 3 + 5); endfunction
  function automatic logic [DW-1:0] w1(int i); return (v1(i) ^ 32'hA5A5_0000) + DW'(i); endfunction
  function automatic logic [DW-1:0] w2(int i); return w1(i) + 32'h0001_0001 * DW'(i + 1); endfunction

  task automatic step(); @(posedge clk); #1; endtask

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input int a, input logic [DW-1:0] d);
    hostWrReq = 1'b1; hostAddr = AW'(a); hostWrData = d;
    step();
    hostWrReq = 1'b0;
  endtask

  task automatic hostReadChk(input string req, input int a, input logic [DW-1:0] exp);
    hostRdReq = 1'b1; hostAddr = AW'(a);
    step();
    hostRdReq = 1'b0;
    chk({req, " hostRdValid"}, DW'(hostRdValid), 1);
    chk({req, " host data"}, dataOut, exp);
  endtask

  task automatic startInfer(input int n);
    neuronCount = (AW+1)'(n); inferStart = 1'b1;
    step();
    inferStart = 1'b0;
  endtask

  task automatic doClear();
    int n = 0;
    clearReq = 1'b1;
    step();
    clearReq = 1'b0;
    while (busy && n < 4 * DEPTH) begin n++; step(); end
    chk("R2 busy length", DW'(n), DW'(DEPTH));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    step();
    // R1 reset state
    chk("R1 busy", DW'(busy), 0);
    chk("R1 running", DW'(running), 0);
    chk("R1 rdValid", DW'(rdValid), 0);
    chk("R1 hostRdValid", DW'(hostRdValid), 0);

    // R2: clear, then bank 1 (host side after reset, R1) is zero
    doClear();
    for (int i = 0; i < DEPTH; i++) hostReadChk("R2 bank1 zero", i, 0);

    // Empty inference flips to bank 0 on the host side
    startInfer(0);
    chk("R4 running after start", DW'(running), 1);
    step();
    chk("R7 empty pass ends", DW'(running), 0);
    for (int i = 0; i < DEPTH; i++) hostReadChk("R2 bank0 zero", i, 0);
    startInfer(0);
    step();

    // R3 host load and readback
    for (int i = 0; i < DEPTH; i++) hostWrite(i, v1(i));
    for (int i = 0; i < DEPTH; i++) hostReadChk("R3 load readback", i, v1(i));

    // Full inference: stream out loaded words, stream in new ones
    startInfer(DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      rdReq = 1'b1; wrReq = 1'b1; wrData = w1(i);
      if (i == 5) begin inferStart = 1'b1; hostWrReq = 1'b1; hostAddr = '0; hostWrData = 32'hDEAD_BEEF; end
      if (i == 6) begin hostRdReq = 1'b1; hostAddr = AW'(3); end
      step();
      inferStart = 1'b0; hostWrReq = 1'b0; hostRdReq = 1'b0;
      chk("R4 rdValid", DW'(rdValid), 1);
      chk("R4 stream data", dataOut, v1(i));
      if (i == 5) chk("R6 still running", DW'(running), 1);
      if (i == 6) chk("R8 no host read while running", DW'(hostRdValid), 0);
    end
    step();
    chk("R7 read past count", DW'(rdValid), 0);
    rdReq = 1'b0; wrReq = 1'b0;
    step();
    chk("R7 pass ended", DW'(running), 0);
    for (int i = 0; i < DEPTH; i++) hostReadChk("R5 R6 R8 written bank", i, w1(i));

    // Short inference of 10: pointers restart, boundary ignored
    startInfer(10);
    for (int i = 0; i < 12; i++) begin
      rdReq = 1'b1; wrReq = 1'b1; wrData = w2(i);
      step();
      if (i < 10) begin
        chk("R4 short rdValid", DW'(rdValid), 1);
        chk("R4 short stream data", dataOut, w1(i));
      end else begin
        chk("R7 short read past count", DW'(rdValid), 0);
      end
    end
    rdReq = 1'b0; wrReq = 1'b0;
    step();
    chk("R7 short pass ended", DW'(running), 0);
    for (int i = 0; i < DEPTH; i++)
      hostReadChk("R5 R7 short bank", i, (i < 10) ? w2(i) : v1(i));

    // R2: clear again and stream zeros
    doClear();
    startInfer(4);
    for (int i = 0; i < 4; i++) begin
      rdReq = 1'b1; wrReq = 1'b1; wrData = 32'h1;
      step();
      chk("R2 zero stream", dataOut, 0);
    end
    rdReq = 1'b0; wrReq = 1'b0;
    step(); step();

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule